// File: doc/BRIEF.md
# Front-End Chain Readout Sequencer with CRC Trailer

This block sequences the readout of one end of a detector module. Software-side commands write an 8-bit control word into it, addressed to this controller by a node number. The word selects whether a trigger alone may start a readout or whether the layer fast-OR must also be present. It also selects whether a frame check sequence is appended and how many daisy-chained front-end chips this end reads. The two controllers of a module share its 25 chips, for instance twelve on one side and thirteen on the other.

Once a trigger is accepted, the block forwards each hit bit arriving on the chip data stream to a serial output, one cycle later. It counts the end markers that close each chip's record. When the configured number of chips has reported, it either appends an 11-bit CRC (polynomial x^11 + x^2 + 1, preset to all ones, MSB first) or ends the frame at once. The frame is closed by a one-cycle end-of-frame pulse. A busy flag covers the whole frame, and triggers that arrive during it are dropped.

Top module: `rc_top`

## Requirements
- R1: A load pulse whose address equals NODE_ID writes cmd_data into the control word; a load with any other address changes nothing. Field positions: bit 0 = force mode, bit 1 = check-sequence enable, bits 6:2 = chip count, bit 7 = spare with no effect.
- R2: While idle, a trigger is accepted when force mode is 1 or fast_or is 1 in the same cycle; busy is 1 from the cycle after the accepting edge.
- R3: With force mode 0, a trigger without fast_or is ignored and busy stays 0.
- R4: During a readout, every din_valid bit appears on ser_data with ser_valid 1 exactly one cycle later, in order; din activity while idle produces no output.
- R5: The data phase ends at the din_last marker that completes the configured chip count; din_last is only seen together with din_valid.
- R6: With check enable 1, the 11 cycles right after the last data bit carry the CRC (x^11 + x^2 + 1, register preset to 0x7FF at frame start, fed MSB first with the data bits), sent MSB first with ser_valid 1.
- R7: The cycle after the last sent bit shows ser_eof 1 with ser_valid 0 and busy 0; with check enable 0 no check bits precede it.
- R8: A trigger arriving while busy is 1 is ignored.
- R9: A chip count of 0 gives an empty frame: the 11 CRC bits of the preset value then ser_eof when check enable is 1, or only ser_eof when it is 0.
- R10: Chip count and check enable are captured at trigger acceptance; a load in the same cycle as the trigger or during a readout applies only to later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_load | input | 1 | Control word load strobe |
| cmd_addr | input | ADDR_W | Target node number of the load |
| cmd_data | input | 8 | Control word value |
| trig | input | 1 | Readout trigger |
| fast_or | input | 1 | Layer fast-OR |
| din_valid | input | 1 | Chip data bit valid |
| din_bit | input | 1 | Chip data bit |
| din_last | input | 1 | End marker of the current chip record |
| ser_valid | output | 1 | Serial output bit valid |
| ser_data | output | 1 | Serial output bit |
| ser_eof | output | 1 | End-of-frame pulse |
| busy | output | 1 | Readout in progress |

## Verification
A control-word load and a trigger can land on the same edge. A trigger can also coincide with the last data bit, a CRC bit or the end-of-frame cycle of a frame still in flight. The bench drives both collisions on purpose: a load is issued together with an accepted trigger and again midway through a readout, and extra triggers are fired right after acceptance and during the check trailer. The behavioural model settles each case by reading the old control word and by dropping any trigger that lands while busy, and it compares every output on every clock.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int CFG_W  = 8;
  localparam int CNT_W  = 5;
  localparam int CRC_W  = 11;
  localparam logic [CRC_W-1:0] CRC_POLY = 11'h005;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_CHECK, ST_END} rc_state_t;

  typedef struct packed {
    logic             spare;
    logic [CNT_W-1:0] n_chips;
    logic             fcs_en;
    logic             force_mode;
  } rc_cfg_t;
endpackage

// File: rtl/rc_cfg_reg.sv
module rc_cfg_reg
  import rc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] NODE_ID = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_load,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CFG_W-1:0]  cmd_data,
  output rc_cfg_t           cfg
);
  logic hit;
  assign hit = cmd_load && (cmd_addr == NODE_ID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cfg <= '0;
    else if (hit) cfg <= rc_cfg_t'(cmd_data);
  end
endmodule

// File: rtl/rc_crc.sv
module rc_crc #(
  parameter int W = 11,
  parameter logic [W-1:0] POLY = 11'h005
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic step_en,
  input  logic step_bit,
  input  logic shift_en,
  output logic msb
);
  logic [W-1:0] rem;

  function automatic logic [W-1:0] crc_next(input logic [W-1:0] c, input logic b);
    logic fb;
    fb = c[W-1] ^ b;
    return {c[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rem <= '1;
    else if (init)     rem <= '1;
    else if (step_en)  rem <= crc_next(rem, step_bit);
    else if (shift_en) rem <= {rem[W-2:0], 1'b0};
  end

  assign msb = rem[W-1];
endmodule

// File: rtl/rc_seq.sv
module rc_seq
  import rc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  rc_cfg_t cfg,
  input  logic    trig,
  input  logic    fast_or,
  input  logic    din_valid,
  input  logic    din_bit,
  input  logic    din_last,
  input  logic    crc_msb,
  output logic    crc_init,
  output logic    crc_step,
  output logic    crc_shift,
  output logic    accept,
  output logic    fcs_lat,
  output logic    ser_valid,
  output logic    ser_data,
  output logic    ser_eof,
  output logic    busy
);
  localparam int TW = $clog2(CRC_W);

  rc_state_t        state;
  logic [CNT_W-1:0] n_lat;
  logic [CNT_W-1:0] done_cnt;
  logic [TW-1:0]    tail_cnt;
  logic             last_chip;

  assign accept    = (state == ST_IDLE) && trig && (cfg.force_mode || fast_or);
  assign last_chip = (state == ST_DATA) && din_valid && din_last &&
                     (({1'b0, done_cnt} + 1'b1) == {1'b0, n_lat});
  assign crc_init  = accept;
  assign crc_step  = (state == ST_DATA) && din_valid;
  assign crc_shift = (state == ST_CHECK);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      n_lat     <= '0;
      done_cnt  <= '0;
      tail_cnt  <= '0;
      fcs_lat   <= 1'b0;
      ser_valid <= 1'b0;
      ser_data  <= 1'b0;
      ser_eof   <= 1'b0;
    end else begin
      ser_valid <= 1'b0;
      ser_eof   <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          n_lat    <= cfg.n_chips;
          fcs_lat  <= cfg.fcs_en;
          done_cnt <= '0;
          tail_cnt <= '0;
          if (cfg.n_chips == '0) state <= cfg.fcs_en ? ST_CHECK : ST_END;
          else                   state <= ST_DATA;
        end
        ST_DATA: if (din_valid) begin
          ser_valid <= 1'b1;
          ser_data  <= din_bit;
          if (din_last)  done_cnt <= done_cnt + 1'b1;
          if (last_chip) state    <= fcs_lat ? ST_CHECK : ST_END;
        end
        ST_CHECK: begin
          ser_valid <= 1'b1;
          ser_data  <= crc_msb;
          tail_cnt  <= tail_cnt + 1'b1;
          if (tail_cnt == TW'(CRC_W - 1)) state <= ST_END;
        end
        default: begin
          ser_eof <= 1'b1;
          state   <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/rc_top.sv
module rc_top
  import rc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] NODE_ID = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_load,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              trig,
  input  logic              fast_or,
  input  logic              din_valid,
  input  logic              din_bit,
  input  logic              din_last,
  output logic              ser_valid,
  output logic              ser_data,
  output logic              ser_eof,
  output logic              busy
);
  rc_cfg_t cfg_q;
  logic    cfg_force;
  logic    crc_init, crc_step, crc_shift, crc_msb;
  logic    trig_accept, fcs_lat;

  assign cfg_force = cfg_q.force_mode;

  rc_cfg_reg #(.ADDR_W(ADDR_W), .NODE_ID(NODE_ID)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cfg(cfg_q)
  );

  rc_crc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .step_en(crc_step),
    .step_bit(din_bit), .shift_en(crc_shift), .msb(crc_msb)
  );

  rc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .trig(trig), .fast_or(fast_or),
    .din_valid(din_valid), .din_bit(din_bit), .din_last(din_last),
    .crc_msb(crc_msb), .crc_init(crc_init), .crc_step(crc_step),
    .crc_shift(crc_shift), .accept(trig_accept), .fcs_lat(fcs_lat),
    .ser_valid(ser_valid), .ser_data(ser_data), .ser_eof(ser_eof), .busy(busy)
  );
endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
  parameter int CRC_W = 11
) (
  input logic clk,
  input logic rst_n,
  input logic trig,
  input logic fast_or,
  input logic cfg_force,
  input logic busy,
  input logic ser_valid,
  input logic ser_eof,
  input logic accept,
  input logic crc_shift,
  input logic fcs_lat
);
  logic [4:0] crc_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         crc_cnt <= '0;
    else if (accept)    crc_cnt <= '0;
    else if (crc_shift) crc_cnt <= crc_cnt + 1'b1;
  end

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  p_no_fastor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trig && !cfg_force && !fast_or) |=> !busy);

  p_valid_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> $past(busy));

  p_busy_ends_eof_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ser_eof);

  p_crc_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_eof |-> (crc_cnt == (fcs_lat ? 5'(CRC_W) : 5'd0)));

  p_eof_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ser_eof |-> (!ser_valid && !busy));
endmodule

bind rc_top rc_checker #(.CRC_W(rc_pkg::CRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .fast_or(fast_or),
  .cfg_force(cfg_force), .busy(busy), .ser_valid(ser_valid),
  .ser_eof(ser_eof), .accept(trig_accept), .crc_shift(crc_shift),
  .fcs_lat(fcs_lat)
);

// File: tb/rc_top_tb.sv
module rc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] NODE = 6'd9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_load = 0, trig = 0, fast_or = 0, din_valid = 0, din_bit = 0, din_last = 0;
  logic [5:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic ser_valid, ser_data, ser_eof, busy;

  int vectors = 0, fails = 0, cyc = 0;
  string cur_req = "R2";

  rc_top #(.ADDR_W(6), .NODE_ID(NODE)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit [7:0] m_cfg;
  int m_phase, m_n, m_done;
  bit m_fcs;
  bit msg[$];
  int tail[$];
  bit e_valid, e_data, e_eof, e_busy;

  function automatic bit [10:0] ref_crc(input bit q[$]);
    int c = 'h7FF;
    foreach (q[i]) begin
      int top = (c >> 10) & 1;
      c = (c << 1) & 'h7FF;
      if ((top ^ q[i]) != 0) c = c ^ 'h005;
    end
    return c[10:0];
  endfunction

  function automatic void build_tail();
    tail.delete();
    if (m_fcs) begin
      bit [10:0] r = ref_crc(msg);
      for (int i = 10; i >= 0; i--) tail.push_back(int'(r[i]));
    end
    tail.push_back(2);
    m_phase = 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 0; m_phase = 0; m_n = 0; m_done = 0; m_fcs = 0;
      e_valid = 0; e_data = 0; e_eof = 0; e_busy = 0;
    end else begin
      e_valid = 0; e_eof = 0;
      case (m_phase)
        0: if (trig && (m_cfg[0] || fast_or)) begin
          m_n = int'(m_cfg[6:2]); m_fcs = m_cfg[1]; msg.delete(); m_done = 0;
          if (m_n == 0) build_tail(); else m_phase = 1;
        end
        1: if (din_valid) begin
          e_valid = 1; e_data = din_bit; msg.push_back(din_bit);
          if (din_last) begin
            m_done++;
            if (m_done == m_n) build_tail();
          end
        end
        default: begin
          int t;
          t = tail.pop_front();
          if (t == 2) begin e_eof = 1; m_phase = 0; end
          else begin e_valid = 1; e_data = t[0]; end
        end
      endcase
      if (cmd_load && cmd_addr == NODE) m_cfg = cmd_data;
      e_busy = (m_phase != 0);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (busy !== e_busy) begin
        fails++; $display("FAIL %s busy actual=%b expected=%b t=%0t", cur_req, busy, e_busy, $time);
      end
      if (ser_valid !== e_valid) begin
        fails++; $display("FAIL %s ser_valid actual=%b expected=%b t=%0t", cur_req, ser_valid, e_valid, $time);
      end
      if (ser_eof !== e_eof) begin
        fails++; $display("FAIL %s ser_eof actual=%b expected=%b t=%0t", cur_req, ser_eof, e_eof, $time);
      end
      if (e_valid && ser_data !== e_data) begin
        fails++; $display("FAIL %s ser_data actual=%b expected=%b t=%0t", cur_req, ser_data, e_data, $time);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog R5 actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic load(input logic [5:0] a, input logic [7:0] d);
    tick(); cmd_load = 1; cmd_addr = a; cmd_data = d;
    tick(); cmd_load = 0;
  endtask

  task automatic fire(input bit fo);
    tick(); trig = 1; fast_or = fo;
    tick(); trig = 0; fast_or = 0;
  endtask

  task automatic chips(input int n, input int len, input bit gaps, input int seed);
    for (int c = 0; c < n; c++) begin
      for (int b = 0; b < len; b++) begin
        tick();
        if (gaps && (b % 3 == 1)) begin din_valid = 0; din_last = 0; tick(); end
        din_valid = 1;
        din_bit   = ((seed + c * 3 + b * 5) % 7) < 3;
        din_last  = (b == len - 1);
      end
    end
    tick(); din_valid = 0; din_last = 0; din_bit = 0;
  endtask

  task automatic settle(); repeat (20) tick(); endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    cur_req = "R2"; tick();              // reset state compared here
    cur_req = "R1"; load(6'd8, 8'h0B);   // wrong address: word stays 0
    fire(0); settle();
    cur_req = "R3"; load(NODE, 8'h0A);   // n=2, check on, force off
    fire(0); settle();
    cur_req = "R4"; chips(1, 5, 0, 1); settle();   // idle din ignored
    cur_req = "R6"; fire(1);
    cur_req = "R8"; fire(1);                        // trigger while busy
    cur_req = "R6"; chips(2, 8, 0, 2);
    cur_req = "R8"; fire(1); settle();              // trigger during trailer
    cur_req = "R7"; load(NODE, 8'h8D);              // n=3, no check, force, spare set
    fire(0); chips(3, 6, 1, 3); settle();
    cur_req = "R5"; load(NODE, 8'h37);              // n=13, check on
    fire(0); chips(13, 4, 0, 4); settle();
    cur_req = "R9"; load(NODE, 8'h03); fire(0); settle();
    load(NODE, 8'h01); fire(0); settle();
    cur_req = "R10"; load(NODE, 8'h05);             // n=1, no check
    tick(); cmd_load = 1; cmd_addr = NODE; cmd_data = 8'h0B; trig = 1;
    tick(); cmd_load = 0; trig = 0;
    chips(1, 7, 0, 5); settle();
    fire(0); load(NODE, 8'h05); chips(2, 5, 1, 6); settle();
    fire(0); chips(1, 9, 0, 7); settle();
    cur_req = "R5"; load(NODE, 8'h7F);              // n=31, check on
    fire(0); chips(31, 3, 0, 8); settle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule